// File: doc/BRIEF.md
# SDRAM Power-Down Sequencer

This block decides when a memory controller drops the SDRAM clock-enable line to put the device into power-down, and how it brings the device back. Entry follows a programmable idle policy: immediately once the device is unselected, or only after 64 or 128 consecutive idle cycles. While the device sleeps, the block withholds the ready indication from the main sequencer. It wakes the device when an access arrives, when the power-down policy is switched off, or when a refresh falls due, because the device performs no refresh of its own in this state.

The wake-up sequence depends on the memory family. SDR and low-power SDR parts need a single NOP with clock enable high. Low-power DDR parts must stay down for a minimum number of cycles and then see NOP for a programmed exit window. DDR2 parts have the same minimum down time and then need one NOP. After the wake-up, the block reports ready again and signals a pending refresh. Once the device falls idle again, it goes back to sleep under the same policy.

Top module: `sdpd_ctrl`

## Requirements
- R1: Power-down is allowed only while `lp_mode` equals 2'b10. Any other value keeps `cke` high. If the value changes while the device is down, the block runs the exit sequence and stays awake.
- R2: After reset, `cke` = 1, `access_ok` = 1, `nop_force` = 0 and `refresh_go` = 0.
- R3: With `pd_timeout` = 2'b00, `cke` goes low one cycle after the first cycle in which the block is enabled, `dev_busy` = 0 and `access_req` = 0.
- R4: With `pd_timeout` = 2'b01, `cke` stays high for 64 idle cycles and goes low one cycle later. With 2'b10 the figures are 128 and one.
- R5: `pd_timeout` = 2'b11 behaves exactly like 2'b00.
- R6: An `access_req` or `dev_busy` cycle during an idle countdown restarts the count from zero.
- R7: With `mem_kind` 2'b00 (SDR) or 2'b01 (low-power SDR), a wake cause during power-down raises `cke` with `nop_force` = 1 for one cycle on the next cycle, and `access_ok` returns on the cycle after that. `tcke_cycles` and `txp_cycles` have no effect for these types.
- R8: With `mem_kind` 2'b10 (low-power DDR), `cke` stays low for at least `tcke_cycles` cycles. `nop_force` is then held for `txp_cycles` cycles (at least one) before `access_ok` returns.
- R9: With `mem_kind` 2'b11 (DDR2), `cke` stays low for at least `tcke_cycles` cycles, followed by exactly one `nop_force` cycle.
- R10: A `refresh_due` strobe is held until served. When the device is down, the strobe wakes it, and `refresh_go` is high for one cycle on the first ready cycle. When the device is already awake, `refresh_go` is high on the next cycle.
- R11: `access_ok` is low in every cycle with `cke` low or `nop_force` high, so requests wait until the exit sequence ends.
- R12: After an access or refresh completes, the block re-enters power-down under the current `pd_timeout` policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_mode | input | 2 | Low-power command field; 2'b10 enables power-down |
| pd_timeout | input | 2 | Idle policy: 00/11 immediate, 01 after 64, 10 after 128 cycles |
| mem_kind | input | 2 | 00 SDR, 01 LP-SDR, 10 LP-DDR, 11 DDR2 |
| tcke_cycles | input | TIME_W | Minimum cycles in power-down (LP-DDR, DDR2) |
| txp_cycles | input | TIME_W | Exit NOP cycles (LP-DDR) |
| dev_busy | input | 1 | Device selected / access in progress |
| access_req | input | 1 | New access request from the sequencer |
| refresh_due | input | 1 | Refresh interval strobe |
| cke | output | 1 | Clock enable to the device |
| nop_force | output | 1 | Command bus must carry NOP |
| access_ok | output | 1 | Sequencer may issue commands |
| refresh_go | output | 1 | One-cycle pulse: issue the pending refresh |

## Verification
Every output comes from a single state register. A change of input seen at one clock edge therefore shows up one cycle later: entry one cycle after an idle cycle, or 65 and 129 cycles after the countdown starts. Exit takes `tcke_cycles` low cycles plus the NOP window, and ready follows the last NOP cycle. The bench changes inputs on the falling edge and works out each expectation from these counts as an absolute cycle number. A monitor samples shortly after each rising edge and compares entries only at the cycle they name. The checks include the last cycle before each transition as well as the first cycle after it.

// File: rtl/sdpd_pkg.sv
package sdpd_pkg;

    typedef enum logic [1:0] {
        PD_AWAKE = 2'd0,
        PD_DOWN  = 2'd1,
        PD_WAKE  = 2'd2
    } pd_state_e;

    typedef enum logic [1:0] {
        MEM_SDR   = 2'b00,
        MEM_LPSDR = 2'b01,
        MEM_LPDDR = 2'b10,
        MEM_DDR2  = 2'b11
    } mem_kind_e;

    localparam logic [1:0] LP_POWER_DOWN = 2'b10;

    // Idle cycles required before entry, per timeout field; 11 is reserved and acts as 00.
    function automatic int unsigned idle_limit(input logic [1:0] sel,
                                               input int unsigned short_wait,
                                               input int unsigned long_wait);
        case (sel)
            2'b01:   return short_wait;
            2'b10:   return long_wait;
            default: return 0;
        endcase
    endfunction

    // DDR-class parts must respect a minimum time in power-down.
    function automatic logic needs_min_hold(input mem_kind_e kind);
        return (kind == MEM_LPDDR) || (kind == MEM_DDR2);
    endfunction

endpackage

// File: rtl/sdpd_idle_timer.sv
module sdpd_idle_timer #(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             armed,
    input  logic [LIM_W-1:0] limit,
    output logic             expired
);
    logic [LIM_W-1:0] count_q;

    assign expired = armed && (count_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            count_q <= '0;
        end else if (!expired) begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/sdpd_phase_timer.sv
module sdpd_phase_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         run,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (start) begin
            count <= W'(1);
        end else if (run && count != TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/sdpd_refresh_flag.sv
module sdpd_refresh_flag (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic served,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else begin
            pending <= strobe || (pending && !served);
        end
    end
endmodule

// File: rtl/sdpd_ctrl.sv
module sdpd_ctrl
    import sdpd_pkg::*;
#(
    parameter int TIME_W     = 8,
    parameter int IDLE_SHORT = 64,
    parameter int IDLE_LONG  = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        lp_mode,
    input  logic [1:0]        pd_timeout,
    input  logic [1:0]        mem_kind,
    input  logic [TIME_W-1:0] tcke_cycles,
    input  logic [TIME_W-1:0] txp_cycles,
    input  logic              dev_busy,
    input  logic              access_req,
    input  logic              refresh_due,
    output logic              cke,
    output logic              nop_force,
    output logic              access_ok,
    output logic              refresh_go
);
    localparam int LIM_W = $clog2(IDLE_LONG + 1);
    localparam int CNT_W = TIME_W + 1;

    pd_state_e        state_q, state_d;
    mem_kind_e        kind;
    logic             enabled, quiet, armed, expired, wake_cause, hold_ok;
    logic             pend, enter_down, enter_wake, wake_done;
    logic [LIM_W-1:0] limit;
    logic [CNT_W-1:0] hold_cnt, nop_cnt, exit_len;

    assign kind       = mem_kind_e'(mem_kind);
    assign enabled    = (lp_mode == LP_POWER_DOWN);
    assign quiet      = enabled && !dev_busy && !access_req;
    assign armed      = (state_q == PD_AWAKE) && quiet && !pend;
    assign limit      = LIM_W'(idle_limit(pd_timeout, IDLE_SHORT, IDLE_LONG));
    assign wake_cause = access_req || refresh_due || pend || !enabled;
    assign hold_ok    = !needs_min_hold(kind) || (hold_cnt >= {1'b0, tcke_cycles});
    assign exit_len   = (kind == MEM_LPDDR && txp_cycles != '0) ? {1'b0, txp_cycles}
                                                                : CNT_W'(1);
    assign wake_done  = (nop_cnt >= exit_len);

    sdpd_idle_timer #(.LIM_W(LIM_W)) u_idle (
        .clk     (clk),
        .rst     (rst),
        .armed   (armed),
        .limit   (limit),
        .expired (expired)
    );

    sdpd_phase_timer #(.W(CNT_W)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .start (enter_down),
        .run   (state_q == PD_DOWN),
        .count (hold_cnt)
    );

    sdpd_phase_timer #(.W(CNT_W)) u_exit (
        .clk   (clk),
        .rst   (rst),
        .start (enter_wake),
        .run   (state_q == PD_WAKE),
        .count (nop_cnt)
    );

    sdpd_refresh_flag u_ref (
        .clk     (clk),
        .rst     (rst),
        .strobe  (refresh_due),
        .served  (refresh_go),
        .pending (pend)
    );

    always_comb begin
        state_d    = state_q;
        enter_down = 1'b0;
        enter_wake = 1'b0;
        unique case (state_q)
            PD_AWAKE: if (expired) begin
                state_d    = PD_DOWN;
                enter_down = 1'b1;
            end
            PD_DOWN: if (wake_cause && hold_ok) begin
                state_d    = PD_WAKE;
                enter_wake = 1'b1;
            end
            PD_WAKE: if (wake_done) begin
                state_d = PD_AWAKE;
            end
            default: state_d = PD_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PD_AWAKE;
        end else begin
            state_q <= state_d;
        end
    end

    assign cke        = (state_q != PD_DOWN);
    assign nop_force  = (state_q == PD_WAKE);
    assign access_ok  = (state_q == PD_AWAKE);
    assign refresh_go = (state_q == PD_AWAKE) && pend;

endmodule

// File: rtl/sdpd_ctrl_checks.sv
module sdpd_ctrl_checks #(
    parameter int TIME_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        lp_mode,
    input logic [1:0]        mem_kind,
    input logic [TIME_W-1:0] tcke_cycles,
    input logic [TIME_W-1:0] txp_cycles,
    input logic              cke,
    input logic              nop_force,
    input logic              access_ok,
    input logic              refresh_go
);
    logic [15:0] low_run, nop_run;

    always_ff @(posedge clk) begin
        if (rst || cke) low_run <= '0;
        else if (low_run != 16'hFFFF) low_run <= low_run + 1'b1;
        if (rst || !nop_force) nop_run <= '0;
        else if (nop_run != 16'hFFFF) nop_run <= nop_run + 1'b1;
    end

    assert_down_not_ready_R11: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (!access_ok && !nop_force));

    assert_nop_with_cke_R7: assert property (@(posedge clk) disable iff (rst)
        nop_force |-> (cke && !access_ok));

    assert_disabled_awake_R1: assert property (@(posedge clk) disable iff (rst)
        (lp_mode != 2'b10 && cke) |=> cke);

    assert_min_hold_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(cke) && mem_kind[1]) |-> (low_run >= 16'(tcke_cycles)));

    assert_exit_window_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(nop_force) && mem_kind == 2'b10) |-> (nop_run >= 16'(txp_cycles)));

    assert_refresh_ready_R10: assert property (@(posedge clk) disable iff (rst)
        refresh_go |-> (access_ok && cke));
endmodule

bind sdpd_ctrl sdpd_ctrl_checks #(.TIME_W(TIME_W)) u_checks (
    .clk         (clk),
    .rst         (rst),
    .lp_mode     (lp_mode),
    .mem_kind    (mem_kind),
    .tcke_cycles (tcke_cycles),
    .txp_cycles  (txp_cycles),
    .cke         (cke),
    .nop_force   (nop_force),
    .access_ok   (access_ok),
    .refresh_go  (refresh_go)
);

// File: tb/sdpd_ctrl_test.sv
module sdpd_ctrl_test;
    localparam int PH_ON   = 0;
    localparam int PH_DOWN = 1;
    localparam int PH_WAKE = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] lp_mode = 2'b00, pd_timeout = 2'b00, mem_kind = 2'b00;
    logic [7:0] tcke_cycles = 8'd0, txp_cycles = 8'd0;
    logic       dev_busy = 1'b1, access_req = 1'b0, refresh_due = 1'b0;
    logic       cke, nop_force, access_ok, refresh_go;

    always #2 clk = ~clk;

    sdpd_ctrl uut (
        .clk(clk), .rst(rst), .lp_mode(lp_mode), .pd_timeout(pd_timeout),
        .mem_kind(mem_kind), .tcke_cycles(tcke_cycles), .txp_cycles(txp_cycles),
        .dev_busy(dev_busy), .access_req(access_req), .refresh_due(refresh_due),
        .cke(cke), .nop_force(nop_force), .access_ok(access_ok), .refresh_go(refresh_go)
    );

    typedef struct {
        int    cyc;
        int    ph;
        logic  rg;
        string tag;
    } item_t;

    item_t exp_q[$];
    item_t it;
    int    cyc = 0;
    int    compared = 0;
    int    mismatched = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares every expectation due in this cycle
    always @(posedge clk) begin
        #1;
        while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
            logic ec, en, eo;
            it = exp_q.pop_front();
            ec = (it.ph != PH_DOWN);
            en = (it.ph == PH_WAKE);
            eo = (it.ph == PH_ON);
            compared++;
            if (it.cyc != cyc || cke !== ec || nop_force !== en ||
                access_ok !== eo || refresh_go !== it.rg) begin
                mismatched++;
                $display("FAIL %s cyc=%0d: actual cke=%b nop=%b ok=%b rg=%b expected cke=%b nop=%b ok=%b rg=%b (due %0d)",
                         it.tag, cyc, cke, nop_force, access_ok, refresh_go,
                         ec, en, eo, it.rg, it.cyc);
            end
        end
    end

    task automatic expect_at(input int d, input int ph, input logic rg, input string tag);
        item_t e;
        e.cyc = cyc + d;
        e.ph  = ph;
        e.rg  = rg;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wake the device with a request and leave it awake and busy
    task automatic wake_and_hold();
        access_req = 1'b1;
        dev_busy   = 1'b1;
        tick(12);
        access_req = 1'b0;
        tick(1);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        expect_at(1, PH_ON, 1'b0, "R2");
        dev_busy = 1'b0;
        expect_at(10, PH_ON, 1'b0, "R1");
        tick(12);

        // Immediate entry, LP-SDR exit ignoring tcke, then re-entry
        mem_kind = 2'b01; tcke_cycles = 8'd5; lp_mode = 2'b10; pd_timeout = 2'b00;
        expect_at(1, PH_DOWN, 1'b0, "R3");
        expect_at(6, PH_DOWN, 1'b0, "R3");
        tick(6);
        access_req = 1'b1;
        expect_at(1, PH_WAKE, 1'b0, "R7");
        expect_at(2, PH_ON, 1'b0, "R7");
        expect_at(4, PH_ON, 1'b0, "R11");
        tick(4);
        access_req = 1'b0;
        expect_at(1, PH_DOWN, 1'b0, "R12");
        tick(3);

        // Timeout 01: 64 idle cycles
        mem_kind = 2'b00; pd_timeout = 2'b01;
        wake_and_hold();
        dev_busy = 1'b0;
        expect_at(64, PH_ON, 1'b0, "R4");
        expect_at(65, PH_DOWN, 1'b0, "R4");
        tick(70);

        // Timeout 10: 128 idle cycles
        pd_timeout = 2'b10;
        wake_and_hold();
        dev_busy = 1'b0;
        expect_at(128, PH_ON, 1'b0, "R4");
        expect_at(129, PH_DOWN, 1'b0, "R4");
        tick(135);

        // Reserved timeout 11 acts as immediate
        pd_timeout = 2'b11;
        wake_and_hold();
        dev_busy = 1'b0;
        expect_at(1, PH_DOWN, 1'b0, "R5");
        tick(3);

        // Request during countdown restarts it
        pd_timeout = 2'b01;
        wake_and_hold();
        dev_busy = 1'b0;
        tick(30);
        access_req = 1'b1;
        tick(1);
        access_req = 1'b0;
        expect_at(64, PH_ON, 1'b0, "R6");
        expect_at(65, PH_DOWN, 1'b0, "R6");
        tick(70);

        // LP-DDR: tcke hold then txp NOPs
        mem_kind = 2'b10; tcke_cycles = 8'd4; txp_cycles = 8'd3; pd_timeout = 2'b00;
        wake_and_hold();
        dev_busy = 1'b0;
        expect_at(1, PH_DOWN, 1'b0, "R8");
        tick(1);
        access_req = 1'b1;
        expect_at(3, PH_DOWN, 1'b0, "R8");
        expect_at(4, PH_WAKE, 1'b0, "R8");
        expect_at(6, PH_WAKE, 1'b0, "R8");
        expect_at(7, PH_ON, 1'b0, "R8");
        tick(8);
        access_req = 1'b0; dev_busy = 1'b1;
        tick(2);

        // DDR2: tcke hold then single NOP
        mem_kind = 2'b11;
        dev_busy = 1'b0;
        expect_at(1, PH_DOWN, 1'b0, "R9");
        tick(1);
        access_req = 1'b1;
        expect_at(3, PH_DOWN, 1'b0, "R9");
        expect_at(4, PH_WAKE, 1'b0, "R9");
        expect_at(5, PH_ON, 1'b0, "R9");
        tick(6);
        access_req = 1'b0; dev_busy = 1'b1;
        tick(2);

        // Refresh wakes the device, pulse, then re-entry
        mem_kind = 2'b00; dev_busy = 1'b0;
        expect_at(1, PH_DOWN, 1'b0, "R3");
        tick(3);
        refresh_due = 1'b1;
        expect_at(1, PH_WAKE, 1'b0, "R10");
        expect_at(2, PH_ON, 1'b1, "R10");
        expect_at(3, PH_ON, 1'b0, "R10");
        expect_at(4, PH_DOWN, 1'b0, "R12");
        tick(1);
        refresh_due = 1'b0;
        tick(5);

        // Disabling power-down while down wakes and stays awake
        lp_mode = 2'b00;
        expect_at(1, PH_WAKE, 1'b0, "R1");
        expect_at(2, PH_ON, 1'b0, "R1");
        expect_at(6, PH_ON, 1'b0, "R1");
        tick(7);

        // Refresh while awake
        refresh_due = 1'b1;
        expect_at(1, PH_ON, 1'b1, "R10");
        expect_at(2, PH_ON, 1'b0, "R10");
        tick(1);
        refresh_due = 1'b0;
        tick(4);

        while (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            compared++;
            mismatched++;
            $display("FAIL %s: expectation for cycle %0d never compared (now %0d)", it.tag, it.cyc, cyc);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not finish, actual cyc=%0d expected end before 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule